// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block drives the four winding ends of a two-phase, center-tapped stepper motor. Each output bit, when 1, grounds one winding end. The excitation is taken from one eight-slot cyclic table. Half-step mode walks every slot. Full-step mode walks only the even slots, which are the patterns with two windings energised. A pointer moves through the table forward (clockwise) or backward (counter-clockwise). One step is taken each time a programmable dwell of `period_i` clock cycles has elapsed.

When enable is low the windings are released (all outputs 0) and the table position is kept. Raising enable again applies the kept entry at once and restarts the dwell. Mode, direction and period are sampled live and act at the next step.

A single-cycle strobe marks every cycle in which the drive pattern changed. This lets a downstream counter or monitor follow the motor.

Top module: `stepper_phase_seq`

## Requirements
- R1: While reset is asserted and on its release, `phase_o` is 4'b0000 and `step_strobe_o` is 0, with the table position at slot 0.
- R2: In any cycle following a clock edge at which `enable_i` was low, `phase_o` is 4'b0000. On the next enable the pattern of the kept slot is applied, not a later one.
- R3: The edge that first samples `enable_i` high applies the current slot. Each applied entry is then held for exactly `period_i` cycles before the next step; a `period_i` of 0 behaves as 1.
- R4: `phase_o` is {X1,X2,Y1,Y2} (bit 3 = X1). In full-step mode with `dir_cw_i`=1 the outputs cycle 0101, 1001, 1010, 0110 and then wrap to 0101.
- R5: In half-step mode with `dir_cw_i`=1 the outputs cycle 0101, 0001, 1001, 1000, 1010, 0010, 0110, 0100 and then wrap. Each step changes one bit.
- R6: With `dir_cw_i`=0 the same tables are walked in reverse order, wrapping from the first entry to the last.
- R7: When the position is a half-step-only slot and a step is taken in full-step mode, the pointer moves one slot in the current direction onto a full-step entry. Later full steps move two slots.
- R8: `step_strobe_o` is high for one cycle in exactly those cycles whose `phase_o` differs from the previous cycle's. This covers steps, enabling and disabling.
- R9: Changes of `period_i`, `half_mode_i` and `dir_cw_i` take effect at the next step without restarting the current dwell. If the elapsed dwell already meets a shortened period, the step happens at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Energise windings and run the sequencer |
| half_mode_i | input | 1 | 1 = half-step table, 0 = full-step |
| dir_cw_i | input | 1 | 1 = forward (clockwise), 0 = backward |
| period_i | input | PERIOD_W | Dwell per step in clock cycles |
| phase_o | output | 4 | Winding drive {X1,X2,Y1,Y2} |
| step_strobe_o | output | 1 | One-cycle pulse on every pattern change |

## Verification
A step and a change of the stepping controls can fall on the same edge. Examples are flipping direction, switching from half to full mode on an odd slot, or shortening the period below the elapsed dwell. A disable can also coincide with a due step. The bench makes these changes on the negative edge just before a due step and at other points in the dwell. A behavioural model with integer position and dwell counters predicts every cycle's pattern and strobe. The model judges which slot is kept, whether the step was taken, and whether the strobe fired.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int unsigned SLOTS = 8;
  localparam int unsigned PTR_W = $clog2(SLOTS);

  typedef logic [3:0]       drive_t;
  typedef logic [PTR_W-1:0] slot_t;

  // Even slots are the two-winding (full-step) entries, odd slots the
  // single-winding intermediates used only in half-step mode.
  function automatic drive_t slot_pattern(input slot_t s);
    drive_t d;
    case (s)
      3'd0:    d = 4'b0101;
      3'd1:    d = 4'b0001;
      3'd2:    d = 4'b1001;
      3'd3:    d = 4'b1000;
      3'd4:    d = 4'b1010;
      3'd5:    d = 4'b0010;
      3'd6:    d = 4'b0110;
      default: d = 4'b0100;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit  = (period_i == '0) ? '0 : period_i - 1'b1;
    tick_o = run_i && (cnt_q >= limit);
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a stopped timer restarts its dwell from zero
  p_dwell_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/phase_pointer.sv
module phase_pointer
  import stepper_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance_i,
  input  logic  half_i,
  input  logic  cw_i,
  output slot_t ptr_o,
  output slot_t ptr_next_o
);
  slot_t ptr_q, delta;

  always_comb begin
    delta = (half_i || ptr_q[0]) ? slot_t'(1) : slot_t'(2);
    if (!advance_i) ptr_next_o = ptr_q;
    else if (cw_i)  ptr_next_o = ptr_q + delta;
    else            ptr_next_o = ptr_q - delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (advance_i) ptr_q <= ptr_next_o;
  end

  assign ptr_o = ptr_q;

  // R7: any full-mode step lands on a two-winding slot
  p_full_lands_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !half_i) |=> !ptr_q[0]);
  // R2: without a step the position is kept
  p_hold_position_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(ptr_q));
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable_i,
  input  logic                half_mode_i,
  input  logic                dir_cw_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [3:0]          phase_o,
  output logic                step_strobe_o
);
  drive_t phase_q, phase_d;
  logic   strobe_q, strobe_d;
  logic   running, run, tick, advance;
  slot_t  ptr, ptr_next;

  assign running = |phase_q;
  assign run     = enable_i && running;
  assign advance = run && tick;

  step_timer #(.PERIOD_W(PERIOD_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run), .period_i(period_i), .tick_o(tick)
  );

  phase_pointer i_pointer (
    .clk(clk), .rst_n(rst_n), .advance_i(advance), .half_i(half_mode_i),
    .cw_i(dir_cw_i), .ptr_o(ptr), .ptr_next_o(ptr_next)
  );

  always_comb begin
    phase_d  = enable_i ? slot_pattern(ptr_next) : 4'b0000;
    strobe_d = (phase_d != phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 4'b0000;
      strobe_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      strobe_q <= strobe_d;
    end
  end

  assign phase_o       = phase_q;
  assign step_strobe_o = strobe_q;

  // R2: released windings after a disabled edge
  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (phase_o == 4'b0000));
  // R8: every pattern change is flagged
  p_strobe_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |-> step_strobe_o);
  // R8: no flag without a change
  p_no_idle_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == $past(phase_o)) |-> !step_strobe_o);
  // R4: never both ends of one winding grounded
  p_no_shorted_winding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_o[3] && phase_o[2]) && !(phase_o[1] && phase_o[0]));
  // R5: a half-mode step changes a single bit
  p_half_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(half_mode_i) && $past(|phase_o) && (|phase_o))
      |-> ($countones(phase_o ^ $past(phase_o)) <= 1));
endmodule

// File: tb/test_stepper_phase_seq.sv
module test_stepper_phase_seq;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable_i, half_mode_i, dir_cw_i;
  logic [PW-1:0] period_i;
  logic [3:0]    phase_o;
  logic          step_strobe_o;

  always #2 clk = ~clk;  // 250 MHz

  stepper_phase_seq #(.PERIOD_W(PW)) i_stepper_phase_seq (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .half_mode_i(half_mode_i),
    .dir_cw_i(dir_cw_i), .period_i(period_i),
    .phase_o(phase_o), .step_strobe_o(step_strobe_o)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string req = "R1";

  // Reference model state
  int   tab[8];
  int   m_pos, m_cnt, m_phase;
  bit   m_on, m_strobe;

  initial begin
    tab[0] = 'b0101; tab[1] = 'b0001; tab[2] = 'b1001; tab[3] = 'b1000;
    tab[4] = 'b1010; tab[5] = 'b0010; tab[6] = 'b0110; tab[7] = 'b0100;
  end

  always @(posedge clk) begin
    int lim, step, nph;
    cycles++;
    if (!rst_n) begin
      m_pos = 0; m_cnt = 0; m_phase = 0; m_on = 0; m_strobe = 0;
    end else begin
      lim  = (period_i == 0) ? 0 : int'(period_i) - 1;
      step = (enable_i && m_on && m_cnt >= lim) ? 1 : 0;
      if (step == 1) begin
        int d;
        d = (half_mode_i || (m_pos % 2 == 1)) ? 1 : 2;
        m_pos = dir_cw_i ? (m_pos + d) % 8 : (m_pos + 8 - d) % 8;
      end
      if (!enable_i || !m_on || step == 1) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      nph      = enable_i ? tab[m_pos] : 0;
      m_strobe = (nph != m_phase);
      m_phase  = nph;
      m_on     = enable_i;
    end
  end

  task automatic check(input string r, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", r, what, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cycles > 0) begin
      check(req, int'(phase_o), m_phase, "phase");
      check("R8", int'(step_strobe_o), int'(m_strobe), "strobe");
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; enable_i = 0; half_mode_i = 0; dir_cw_i = 1; period_i = 3;
    wait_cyc(3);
    // R1: reset state
    check("R1", int'(phase_o), 0, "reset phase");
    check("R1", int'(step_strobe_o), 0, "reset strobe");
    rst_n = 1'b1;
    wait_cyc(2);

    // R4 / R3: full-step clockwise, dwell 3
    req = "R4"; enable_i = 1;
    wait_cyc(1);
    check("R4", int'(phase_o), 'b0101, "first full entry");
    check("R8", int'(step_strobe_o), 1, "enable strobe");
    wait_cyc(3);
    check("R3", int'(phase_o), 'b1001, "after one dwell");
    wait_cyc(30);

    // R2: disable mid-sequence, position kept
    req = "R2"; enable_i = 0;
    wait_cyc(5);
    check("R2", int'(phase_o), 0, "released");
    enable_i = 1;
    wait_cyc(20);

    // R5 / R3: half-step clockwise, period 1 then 0
    req = "R5"; half_mode_i = 1; period_i = 1;
    wait_cyc(20);
    req = "R3"; period_i = 0;
    wait_cyc(12);

    // R6: counter-clockwise in both modes
    req = "R6"; dir_cw_i = 0; period_i = 2;
    wait_cyc(20);
    half_mode_i = 0;
    wait_cyc(20);

    // R7: leave half mode from an odd slot, both directions
    req = "R7"; half_mode_i = 1; period_i = 4; dir_cw_i = 1;
    wait_cyc(6);
    half_mode_i = 0;
    wait_cyc(20);
    half_mode_i = 1; dir_cw_i = 0;
    wait_cyc(6);
    half_mode_i = 0;
    wait_cyc(20);

    // R9: controls changed at and inside a dwell
    req = "R9"; period_i = 10;
    wait_cyc(25);
    period_i = 2;          // shortened below elapsed dwell
    wait_cyc(9);
    dir_cw_i = 1; half_mode_i = 1;
    wait_cyc(15);
    period_i = 5;
    wait_cyc(4);
    enable_i = 0;          // disable as a step falls due
    wait_cyc(3);
    enable_i = 1;
    wait_cyc(30);

    // R8: rapid enable toggling
    req = "R8";
    for (int i = 0; i < 6; i++) begin
      enable_i = ~enable_i;
      wait_cyc(1 + i % 3);
    end
    wait_cyc(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule